// File: doc/BRIEF.md
# PIO Sector Transfer Sequencer

This block is the device-side controller that carries out programmed-I/O sector reads, read-verifies and writes for a disk task file. After the host loads a starting cylinder, head, sector and count, the block checks each address against the configured geometry and asks a media stub for each sector. The stub answers through a request/done/error handshake. The block moves 256 sixteen-bit words per sector through a host data stream and steps the address from one sector to the next. It also drives the busy, data-request and interrupt lines in the order each command type needs.

A separate geometry command sets the sectors per track and the highest head number. The block does not check these values. Reads raise an interrupt at every sector that is ready to drain. Writes raise no interrupt for the first sector but do for each later sector and at completion. Verify moves no data and interrupts only at the end. An error stops the command with the task file pointing at the failing sector.

Top module: `pio_sector_seq`

## Requirements
- R1: After reset, busy, drq, intrq and err are 0, the error code is 8'h01, the count is 1, the sector is 1, and the cylinder and head are 0.
- R2: A geometry command (op 2'b11) takes the sectors per track from cmd_count and the highest head from cmd_head without any check. It holds busy high for one cycle, then clears busy and raises intrq.
- R3: A count of 0 means 256 sectors. The count drops by one for each finished sector and reads 0 after a successful command. It never changes while drq stays high.
- R4: Read (op 2'b00): when a sector is ready, drq rises, busy is low and intrq is raised. After the final word, the block sets busy for the next sector. After the last sector it ends with busy, drq and intrq all low.
- R5: Write (op 2'b10): the first drq comes with no interrupt. After 256 words, drq falls and busy rises. Each later drq raises intrq. After the last sector, busy clears and intrq is raised with drq low.
- R6: Verify (op 2'b01) never raises drq. It keeps busy high until all sectors are checked, then raises intrq.
- R7: The sector advances from 1 up to the sectors-per-track value, then wraps to 1 and the head increments. A head wrap past the highest head returns the head to 0 and increments the 16-bit cylinder. On success, the task file holds the last sector processed.
- R8: A sector of 0, a sector above the sectors per track, or a head above the highest head ends the command. It sets err with code 8'h10 (bit 4) and raises intrq. No media request is made.
- R9: A media error ends the command. It sets err with code 8'h04 (bit 2) and raises intrq. The count keeps the remaining sectors, including the failing one, and the address stays at the failing sector. While err is 1, busy and drq are 0.
- R10: Each sector takes exactly 256 beats. rd_valid and wr_ready are high only while drq is high, so a host access while drq is low has no effect.
- R11: A pulse on stat_rd clears intrq, and so does accepting a command. A command is accepted only when the block is idle; otherwise it is ignored.
- R12: busy and drq are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe (taken only when idle) |
| cmd_op | input | 2 | 00 read, 01 verify, 10 write, 11 geometry |
| cmd_count | input | 8 | Sector count / sectors per track |
| cmd_sector | input | 8 | Starting sector |
| cmd_cyl | input | 16 | Starting cylinder |
| cmd_head | input | 4 | Starting head / highest head |
| stat_rd | input | 1 | Host status read, clears intrq |
| busy | output | 1 | Busy flag |
| drq | output | 1 | Data request flag |
| intrq | output | 1 | Interrupt request |
| err | output | 1 | Command ended in error |
| err_code | output | 8 | Error code |
| tf_count | output | 8 | Remaining sector count |
| tf_sector | output | 8 | Current sector |
| tf_cyl | output | 16 | Current cylinder |
| tf_head | output | 4 | Current head |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Host takes read word |
| rd_data | output | 16 | Read word |
| wr_valid | input | 1 | Host offers write word |
| wr_ready | output | 1 | Block accepts write word |
| wr_data | input | 16 | Write word |
| med_req | output | 1 | Media access request for the task-file address |
| med_op | output | 2 | Media operation, same coding as cmd_op |
| med_word_idx | output | 8 | Word index within the sector |
| med_rdata | input | 16 | Media word at med_word_idx |
| med_wdata | output | 16 | Word passed to media |
| med_wr_en | output | 1 | Write word strobe to media |
| med_done | input | 1 | One-cycle completion of the request |
| med_err | input | 1 | Error qualifier with med_done |

## Verification
The assertions assume that med_done arrives only while med_req is high, as a single-cycle pulse. They also assume that the stream inputs are the only path by which data moves, so a beat counts only when valid and ready meet. The stimulus media stub answers each request once, a few cycles after it sees the request, and stays silent at all other times. The host tasks hold rd_ready or wr_valid only around drq windows. Stray wr_valid strobes are driven on purpose while the block is busy, so that the gating can be observed at the ports.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_VERIFY = 2'd1,
    OP_WRITE  = 2'd2,
    OP_GEOM   = 2'd3
  } pio_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_MED,
    ST_XFER,
    ST_GEOM
  } pio_st_e;

  localparam logic [7:0] ERRC_RESET = 8'h01;
  localparam logic [7:0] ERRC_NONE  = 8'h00;
  localparam logic [7:0] ERRC_IDNF  = 8'h10;
  localparam logic [7:0] ERRC_ABRT  = 8'h04;
endpackage

// File: rtl/pio_geom_check.sv
module pio_geom_check #(
  parameter int SEC_W  = 8,
  parameter int HEAD_W = 4
) (
  input  logic [SEC_W-1:0]  sector,
  input  logic [HEAD_W-1:0] head,
  input  logic [SEC_W-1:0]  spt,
  input  logic [HEAD_W-1:0] max_head,
  output logic              addr_ok
);
  assign addr_ok = (sector != '0) && (sector <= spt) && (head <= max_head);
endmodule

// File: rtl/pio_addr_step.sv
module pio_addr_step #(
  parameter int SEC_W  = 8,
  parameter int HEAD_W = 4,
  parameter int CYL_W  = 16
) (
  input  logic [SEC_W-1:0]  sector,
  input  logic [HEAD_W-1:0] head,
  input  logic [CYL_W-1:0]  cyl,
  input  logic [SEC_W-1:0]  spt,
  input  logic [HEAD_W-1:0] max_head,
  output logic [SEC_W-1:0]  nxt_sector,
  output logic [HEAD_W-1:0] nxt_head,
  output logic [CYL_W-1:0]  nxt_cyl
);
  always_comb begin
    nxt_sector = sector + 1'b1;
    nxt_head   = head;
    nxt_cyl    = cyl;
    if (sector >= spt) begin
      nxt_sector = SEC_W'(1);
      if (head >= max_head) begin
        nxt_head = '0;
        nxt_cyl  = cyl + 1'b1;
      end else begin
        nxt_head = head + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pio_word_ctr.sv
module pio_word_ctr #(
  parameter int WORDS = 256,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          beat,
  output logic [IW-1:0] idx,
  output logic          last
);
  assign last = (idx == IW'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clr)    idx <= '0;
    else if (beat)   idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/pio_sector_seq.sv
module pio_sector_seq
  import pio_seq_pkg::*;
#(
  parameter int WORDS    = 256,
  parameter int SEC_W    = 8,
  parameter int HEAD_W   = 4,
  parameter int CYL_W    = 16,
  parameter int DATA_W   = 16,
  parameter int DEF_SPT  = 17,
  parameter int DEF_MAXH = 15,
  localparam int IW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SEC_W-1:0]  cmd_count,
  input  logic [SEC_W-1:0]  cmd_sector,
  input  logic [CYL_W-1:0]  cmd_cyl,
  input  logic [HEAD_W-1:0] cmd_head,
  input  logic              stat_rd,
  output logic              busy,
  output logic              drq,
  output logic              intrq,
  output logic              err,
  output logic [7:0]        err_code,
  output logic [SEC_W-1:0]  tf_count,
  output logic [SEC_W-1:0]  tf_sector,
  output logic [CYL_W-1:0]  tf_cyl,
  output logic [HEAD_W-1:0] tf_head,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              med_req,
  output logic [1:0]        med_op,
  output logic [IW-1:0]     med_word_idx,
  input  logic [DATA_W-1:0] med_rdata,
  output logic [DATA_W-1:0] med_wdata,
  output logic              med_wr_en,
  input  logic              med_done,
  input  logic              med_err
);
  pio_st_e             st;
  pio_op_e             op;
  logic [SEC_W-1:0]    spt;
  logic [HEAD_W-1:0]   max_head;
  logic                first_blk;
  logic                addr_ok;
  logic [SEC_W-1:0]    nxt_sector;
  logic [HEAD_W-1:0]   nxt_head;
  logic [CYL_W-1:0]    nxt_cyl;
  logic                beat;
  logic                word_last;
  logic                accept;
  logic                last_sec;
  logic                irq_set;

  pio_geom_check #(.SEC_W(SEC_W), .HEAD_W(HEAD_W)) u_geom (
    .sector(tf_sector), .head(tf_head), .spt(spt), .max_head(max_head),
    .addr_ok(addr_ok)
  );

  pio_addr_step #(.SEC_W(SEC_W), .HEAD_W(HEAD_W), .CYL_W(CYL_W)) u_step (
    .sector(tf_sector), .head(tf_head), .cyl(tf_cyl), .spt(spt),
    .max_head(max_head), .nxt_sector(nxt_sector), .nxt_head(nxt_head),
    .nxt_cyl(nxt_cyl)
  );

  pio_word_ctr #(.WORDS(WORDS)) u_words (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_XFER), .beat(beat),
    .idx(med_word_idx), .last(word_last)
  );

  assign busy      = (st == ST_CHK) || (st == ST_MED) || (st == ST_GEOM);
  assign drq       = (st == ST_XFER);
  assign rd_valid  = drq && (op == OP_READ);
  assign wr_ready  = drq && (op == OP_WRITE);
  assign rd_data   = med_rdata;
  assign med_wdata = wr_data;
  assign med_wr_en = wr_valid && wr_ready;
  assign med_req   = (st == ST_MED);
  assign med_op    = op;
  assign beat      = (rd_valid && rd_ready) || (wr_valid && wr_ready);
  assign accept    = (st == ST_IDLE) && cmd_valid;
  assign last_sec  = (tf_count == SEC_W'(1));

  always_comb begin
    irq_set = 1'b0;
    unique case (st)
      ST_GEOM: irq_set = 1'b1;
      ST_CHK:  irq_set = !addr_ok || (op == OP_WRITE && !first_blk);
      ST_MED:  if (med_done)
                 irq_set = med_err || (op == OP_READ) || last_sec;
      default: irq_set = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op        <= OP_READ;
      spt       <= SEC_W'(DEF_SPT);
      max_head  <= HEAD_W'(DEF_MAXH);
      first_blk <= 1'b0;
      tf_count  <= SEC_W'(1);
      tf_sector <= SEC_W'(1);
      tf_cyl    <= '0;
      tf_head   <= '0;
      err       <= 1'b0;
      err_code  <= ERRC_RESET;
      intrq     <= 1'b0;
    end else begin
      if (irq_set)                 intrq <= 1'b1;
      else if (stat_rd || accept)  intrq <= 1'b0;

      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          op        <= pio_op_e'(cmd_op);
          tf_count  <= cmd_count;
          tf_sector <= cmd_sector;
          tf_cyl    <= cmd_cyl;
          tf_head   <= cmd_head;
          err       <= 1'b0;
          err_code  <= ERRC_NONE;
          first_blk <= 1'b1;
          if (pio_op_e'(cmd_op) == OP_GEOM) begin
            spt      <= cmd_count;
            max_head <= cmd_head;
            st       <= ST_GEOM;
          end else begin
            st <= ST_CHK;
          end
        end
        ST_GEOM: st <= ST_IDLE;
        ST_CHK: begin
          if (!addr_ok) begin
            err      <= 1'b1;
            err_code <= ERRC_IDNF;
            st       <= ST_IDLE;
          end else if (op == OP_WRITE) begin
            first_blk <= 1'b0;
            st        <= ST_XFER;
          end else begin
            st <= ST_MED;
          end
        end
        ST_MED: if (med_done) begin
          if (med_err) begin
            err      <= 1'b1;
            err_code <= ERRC_ABRT;
            st       <= ST_IDLE;
          end else if (op == OP_READ) begin
            st <= ST_XFER;
          end else begin
            tf_count <= tf_count - 1'b1;
            if (last_sec) begin
              st <= ST_IDLE;
            end else begin
              tf_sector <= nxt_sector;
              tf_head   <= nxt_head;
              tf_cyl    <= nxt_cyl;
              st        <= ST_CHK;
            end
          end
        end
        ST_XFER: if (beat && word_last) begin
          if (op == OP_WRITE) begin
            st <= ST_MED;
          end else begin
            tf_count <= tf_count - 1'b1;
            if (last_sec) begin
              st <= ST_IDLE;
            end else begin
              tf_sector <= nxt_sector;
              tf_head   <= nxt_head;
              tf_cyl    <= nxt_cyl;
              st        <= ST_CHK;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk #(
  parameter int SEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             drq,
  input logic             err,
  input logic             intrq,
  input logic             stat_rd,
  input logic             rd_valid,
  input logic             wr_ready,
  input logic             med_req,
  input logic [SEC_W-1:0] tf_count
);
  a_r12_busy_drq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && drq));

  a_r9_err_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !drq));

  a_r10_stream_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_ready) |-> drq);

  a_r6_media_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    med_req |-> busy);

  a_r3_count_steady_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && $past(drq)) |-> $stable(tf_count));

  a_r11_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !busy && !drq) |=> !intrq);
endmodule

bind pio_sector_seq pio_seq_chk #(.SEC_W(SEC_W)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .drq(drq), .err(err),
  .intrq(intrq), .stat_rd(stat_rd), .rd_valid(rd_valid),
  .wr_ready(wr_ready), .med_req(med_req), .tf_count(tf_count)
);

// File: tb/pio_sector_seq_test.sv
module pio_sector_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_count = 8'd0;
  logic [7:0]  cmd_sector = 8'd0;
  logic [15:0] cmd_cyl = 16'd0;
  logic [3:0]  cmd_head = 4'd0;
  logic        stat_rd = 1'b0;
  logic        busy, drq, intrq, err;
  logic [7:0]  err_code, tf_count, tf_sector;
  logic [15:0] tf_cyl;
  logic [3:0]  tf_head;
  logic        rd_valid, wr_ready, med_req, med_wr_en;
  logic        rd_ready = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] rd_data, med_rdata, med_wdata;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  med_op;
  logic [7:0]  med_word_idx;
  logic        med_done = 1'b0;
  logic        med_err = 1'b0;

  int checks = 0;
  int failures = 0;
  int req_no = 0;
  int fail_req = -1;
  int spt_m = 17;
  int maxh_m = 15;
  logic drq_seen = 1'b0;
  logic [29:0] exp_q[$];

  always #5 clk = ~clk;

  pio_sector_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .cmd_sector(cmd_sector), .cmd_cyl(cmd_cyl),
    .cmd_head(cmd_head), .stat_rd(stat_rd), .busy(busy), .drq(drq),
    .intrq(intrq), .err(err), .err_code(err_code), .tf_count(tf_count),
    .tf_sector(tf_sector), .tf_cyl(tf_cyl), .tf_head(tf_head),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .med_req(med_req), .med_op(med_op), .med_word_idx(med_word_idx),
    .med_rdata(med_rdata), .med_wdata(med_wdata), .med_wr_en(med_wr_en),
    .med_done(med_done), .med_err(med_err)
  );

  function automatic logic [15:0] pat(input logic [15:0] c, input logic [3:0] h,
                                      input logic [7:0] s, input logic [7:0] i);
    return 16'(c * 7 + h * 131 + s * 17 + i * 257);
  endfunction

  assign med_rdata = pat(tf_cyl, tf_head, tf_sector, med_word_idx);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // scoreboard driver: pushes the expected media address sequence
  task automatic issue(input logic [1:0] op, input logic [7:0] cnt, input logic [7:0] sec,
                       input logic [15:0] cyl, input logic [3:0] hd);
    int n;
    int s;
    int h;
    int c;
    if (op != 2'd3) begin
      n = (cnt == 0) ? 256 : int'(cnt);
      s = int'(sec); h = int'(hd); c = int'(cyl);
      for (int k = 0; k < n; k++) begin
        if (s == 0 || s > spt_m || h > maxh_m) break;
        exp_q.push_back({op, 16'(c), 4'(h), 8'(s)});
        if (s >= spt_m) begin
          s = 1;
          if (h >= maxh_m) begin h = 0; c++; end else h++;
        end else s++;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_count = cnt; cmd_sector = sec;
    cmd_cyl = cyl; cmd_head = hd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || drq) @(negedge clk);
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic read_sector(input int nwords);
    int bad;
    logic [15:0] expw;
    bad = 0;
    while (!drq) @(negedge clk);
    chk("R4 intrq at read drq", intrq, 1);
    chk("R4 busy low at read drq", busy, 0);
    stat_rd = 1'b1;
    for (int i = 0; i < nwords; i++) begin
      rd_ready = 1'b1;
      expw = pat(tf_cyl, tf_head, tf_sector, 8'(i));
      if (!rd_valid || rd_data !== expw) bad++;
      @(negedge clk);
      stat_rd = 1'b0;
    end
    rd_ready = 1'b0;
    chk("R10 read words", bad, 0);
  endtask

  task automatic write_words(input int nwords);
    for (int i = 0; i < nwords; i++) begin
      wr_valid = 1'b1;
      wr_data = 16'(i);
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  // media stub and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (med_req) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R7 media request act=%h exp=none",
                   {med_op, tf_cyl, tf_head, tf_sector});
        end else begin
          chk("R7 media address", {2'b0, med_op, tf_cyl, tf_head, tf_sector},
              {2'b0, exp_q.pop_front()});
          checks--;
        end
        repeat (2) @(negedge clk);
        med_err = (req_no == fail_req);
        med_done = 1'b1;
        req_no++;
        @(negedge clk);
        med_done = 1'b0;
        med_err = 1'b0;
      end
    end
  end

  always @(negedge clk) if (drq) drq_seen = 1'b1;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 drq", drq, 0);
    chk("R1 intrq", intrq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err_code", err_code, 8'h01);
    chk("R1 count/sector", {tf_count, tf_sector}, 16'h0101);
    chk("R1 cyl/head", {tf_cyl, tf_head}, 0);

    // R2 geometry: 4 sectors per track, heads 0..1
    issue(2'd3, 8'd4, 8'd0, 16'd0, 4'd1);
    spt_m = 4; maxh_m = 1;
    chk("R2 busy one cycle", busy, 1);
    @(negedge clk);
    chk("R2 busy cleared", busy, 0);
    chk("R2 intrq raised", intrq, 1);
    pulse_stat();
    chk("R11 stat_rd clears intrq", intrq, 0);

    // R4/R7 read of three sectors across a cylinder wrap
    issue(2'd0, 8'd3, 8'd3, 16'd5, 4'd1);
    read_sector(256);
    @(negedge clk);
    chk("R4 busy between sectors", busy, 1);
    read_sector(256);
    read_sector(256);
    chk("R4 end busy/drq/intrq", {busy, drq, intrq}, 3'b000);
    chk("R3 count zero after read", tf_count, 0);
    chk("R7 final address", {tf_cyl, tf_head, tf_sector}, {16'd6, 4'd0, 8'd1});
    chk("R7 read queue drained", exp_q.size(), 0);

    // R5/R10 write of two sectors
    issue(2'd2, 8'd2, 8'd4, 16'd2, 4'd0);
    while (!drq) @(negedge clk);
    chk("R5 no intrq before first block", intrq, 0);
    write_words(256);
    chk("R5 busy after block", {busy, drq}, 2'b10);
    wr_valid = 1'b1;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    while (!drq) @(negedge clk);
    chk("R5 intrq for later block", intrq, 1);
    pulse_stat();
    write_words(255);
    chk("R10 stray beats ignored, drq held", drq, 1);
    write_words(1);
    chk("R10 drq drops after 256", drq, 0);
    wait_idle();
    chk("R5 completion intrq", {intrq, drq, busy}, 3'b100);
    chk("R3 count zero after write", tf_count, 0);
    chk("R7 write final address", {tf_cyl, tf_head, tf_sector}, {16'd2, 4'd1, 8'd1});
    pulse_stat();

    // R6 verify, with an ignored command while busy (R11)
    drq_seen = 1'b0;
    issue(2'd1, 8'd2, 8'd3, 16'd1, 4'd1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_count = 8'd9; cmd_sector = 8'd1;
    cmd_cyl = 16'd77; cmd_head = 4'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 busy command ignored", tf_cyl, 16'd1);
    chk("R6 no intrq while verifying", intrq, 0);
    wait_idle();
    chk("R6 drq never seen", drq_seen, 0);
    chk("R6 completion intrq", intrq, 1);
    chk("R6 final address", {tf_count, tf_cyl, tf_head, tf_sector}, {8'd0, 16'd1, 4'd1, 8'd4});
    pulse_stat();

    // R3 count 0 means 256 sectors
    issue(2'd1, 8'd0, 8'd1, 16'd0, 4'd0);
    wait_idle();
    chk("R3 256 sectors done", exp_q.size(), 0);
    chk("R3 count after 256", tf_count, 0);
    chk("R7 address after 256", {tf_cyl, tf_head, tf_sector}, {16'd31, 4'd1, 8'd4});
    pulse_stat();

    // R9 media error on second sector of a read
    fail_req = req_no + 1;
    issue(2'd0, 8'd3, 8'd1, 16'd0, 4'd0);
    read_sector(256);
    wait_idle();
    chk("R9 err and code", {err, err_code}, {1'b1, 8'h04});
    chk("R9 remaining count", tf_count, 8'd2);
    chk("R9 failing address", {tf_cyl, tf_head, tf_sector}, {16'd0, 4'd0, 8'd2});
    chk("R9 intrq, idle", {intrq, busy, drq}, 3'b100);
    exp_q.delete();
    fail_req = -1;
    pulse_stat();

    // R8 geometry errors
    issue(2'd0, 8'd5, 8'd5, 16'd0, 4'd0);
    wait_idle();
    chk("R8 sector beyond track", {err, err_code, intrq}, {1'b1, 8'h10, 1'b1});
    chk("R8 count held", tf_count, 8'd5);
    pulse_stat();
    issue(2'd1, 8'd1, 8'd1, 16'd0, 4'd2);
    wait_idle();
    chk("R8 head beyond max", {err, err_code}, {1'b1, 8'h10});
    chk("R8 no media request", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule